// File: doc/BRIEF.md
# Intermediate-Frequency Gated Pulse-Density Modulator

This block is a cycle-level digital model of the high-band path of a polar transmitter. One clock tick stands for one unit of delay. A carrier square wave whose period is `2**PH_BITS` ticks keeps a 50% duty cycle. Its rising edge is shifted by a phase code. A second, slower signal (the IF gate) repeats every `if_period` ticks. It is high for a share of each IF period set by an envelope code. The one-bit output is the AND of the two signals. The envelope therefore reaches the output as the number of full-width carrier pulses that pass in each IF period, while every pulse keeps its width.

The block rejects configurations that would put IF products on top of the signal band, or that could starve low envelopes of whole pulses. For these it raises a flag and holds the output low. A hysteretic band selector turns a carrier-frequency code into a high/low band choice, and the modulator runs only while the high band is selected and the mode enable is set. For checking, a counter reports how many carrier pulses passed untouched by the gate edges in the IF period that has just ended.

Top module: `ifgate_pdm`

## Requirements
- R1: While `rst_n` is low, `pdm_out`, `band_high` and `whole_cnt` are 0.
- R2: With CP = 2**PH_BITS and H = CP/2, carrier period n covers ticks n*CP to n*CP+CP-1. Its carrier pulse is high for exactly H consecutive ticks, starting at tick n*CP+p, where p is the phase code in force for that period. A pulse may run on into the next period.
- R3: The IF gate is high during the first floor(e*if_period / 2**ENV_BITS) ticks of each IF period and low for the rest, where e is the envelope code in force for that period.
- R4: Tick 0 is the first clock edge at which the block runs. After the edge of tick k, `pdm_out` shows the AND of the carrier and the gate for tick k.
- R5: `phase_in` is sampled only at the last tick of each carrier period, and `env_in` only at the last tick of each IF period. Each takes effect from the next period, so changes between those ticks have no effect. While idle, both are sampled on every clock, and that value governs period 0.
- R6: After the last tick of IF period m, `whole_cnt` gives the number of carrier pulses that lay fully inside period m's gate window. The value holds until the end of the next IF period.
- R7: When `if_period` is a multiple of H (the carrier-to-IF frequency ratio is a multiple of 0.5, zero included), `cfg_err_ratio` is 1 and `pdm_out` is 0 from the next edge on.
- R8: With ENV_MIN = ceil(0.1 * 2**ENV_BITS), `cfg_err_short` is 1 when floor(ENV_MIN*if_period / 2**ENV_BITS) < 2*CP + H - 1. While it is set, `pdm_out` is 0.
- R9: With no configuration error, every IF period whose envelope code is at least ENV_MIN lets at least one whole carrier pulse through (`whole_cnt` >= 1).
- R10: One edge after `fc_code` > BAND_UP, `band_high` is 1. One edge after `fc_code` < BAND_DN, it is 0. For codes between the two thresholds it keeps its value.
- R11: While `mode_en` is 0, `band_high` is 0, or a configuration error is flagged, `pdm_out` is 0 from the next edge on. The tick count restarts at 0 when running resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one unit delay per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_en | input | 1 | Enables the modulator |
| fc_code | input | FC_BITS | Carrier-frequency code for band selection |
| phase_in | input | PH_BITS | Phase code, one tick of lag per step |
| env_in | input | ENV_BITS | Envelope code, gate length in 1/2**ENV_BITS of an IF period |
| if_period | input | IFP_BITS | IF period in ticks |
| pdm_out | output | 1 | Gated, phase-shifted carrier |
| band_high | output | 1 | 1 while the high band is selected |
| cfg_err_ratio | output | 1 | IF period is a multiple of half the carrier period |
| cfg_err_short | output | 1 | Minimum envelope window is too short for a whole pulse |
| whole_cnt | output | IFP_BITS | Whole carrier pulses passed in the last completed IF period |

## Verification
A carrier counter or latched phase that slips shows up at `pdm_out` within one carrier period, as a pulse that starts at the wrong tick or has the wrong width. A wrong IF counter or latched envelope moves the gate edge, so the pulse pattern differs within one IF period, and `whole_cnt` disagrees at the end of that period. The bench compares `pdm_out` tick by tick against an arithmetic model over all phase and envelope codes of a small configuration, including alternating extreme phases and inputs disturbed in the middle of a period. A band register that chatters, or a configuration check that misses, is exposed within one edge by `band_high` or by a stray high on `pdm_out`.

// File: rtl/ifgate_pdm_pkg.sv
package ifgate_pdm_pkg;

  // band chosen by the hysteretic selector
  typedef enum logic {
    BAND_LOW  = 1'b0,
    BAND_HIGH = 1'b1
  } band_e;

  // per-tick carrier view handed from the carrier generator to the top
  typedef struct packed {
    logic level;   // delayed 50% carrier
    logic ends;    // this tick is the last tick of a carrier pulse
  } carr_t;

endpackage

// File: rtl/ifgate_pdm_band_sel.sv
module ifgate_pdm_band_sel
  import ifgate_pdm_pkg::*;
#(
  parameter int FC_BITS = 11,
  parameter int BAND_UP = 100,
  parameter int BAND_DN = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FC_BITS-1:0] fc_code,
  output band_e              band_o
);

  localparam logic [FC_BITS-1:0] UP_W = FC_BITS'(BAND_UP);
  localparam logic [FC_BITS-1:0] DN_W = FC_BITS'(BAND_DN);

  band_e band_q, band_d;

  always_comb begin
    band_d = band_q;
    if (fc_code > UP_W) begin
      band_d = BAND_HIGH;
    end else if (fc_code < DN_W) begin
      band_d = BAND_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= BAND_LOW;
    end else begin
      band_q <= band_d;
    end
  end

  assign band_o = band_q;

endmodule

// File: rtl/ifgate_pdm_carrier.sv
module ifgate_pdm_carrier
  import ifgate_pdm_pkg::*;
#(
  parameter int PH_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PH_BITS-1:0] phase_in,
  output carr_t              carr_o
);

  localparam int CP = 1 << PH_BITS;
  localparam int H  = CP / 2;
  localparam int W  = PH_BITS + 1;
  localparam logic [W-1:0]       CP_W   = W'(CP);
  localparam logic [W-1:0]       H1_W   = W'(H - 1);
  localparam logic [PH_BITS-1:0] IDLE_P = PH_BITS'(H);

  logic [PH_BITS-1:0] cc_q, cc_d;
  logic [PH_BITS-1:0] ph_q, ph_d;
  logic [PH_BITS-1:0] prev_q, prev_d;

  logic [W-1:0] cc_x, ph_x, prev_x, main_stop, tail_stop, cc_wrap;
  logic         main_on, tail_on, main_end, tail_end, period_last;

  assign cc_x      = {1'b0, cc_q};
  assign ph_x      = {1'b0, ph_q};
  assign prev_x    = {1'b0, prev_q};
  assign main_stop = ph_x + H1_W;
  assign tail_stop = prev_x + H1_W;
  assign cc_wrap   = cc_x + CP_W;

  // pulse that rises in this period, and the remainder of last period's pulse
  assign main_on  = (cc_x >= ph_x) && (cc_x <= main_stop);
  assign tail_on  = (cc_wrap <= tail_stop);
  assign main_end = (main_stop < CP_W) && (cc_x == main_stop);
  assign tail_end = (tail_stop >= CP_W) && (cc_wrap == tail_stop);

  assign period_last = &cc_q;

  always_comb begin
    cc_d   = cc_q;
    ph_d   = ph_q;
    prev_d = prev_q;
    if (run) begin
      cc_d = cc_q + 1'b1;
      if (period_last) begin
        ph_d   = phase_in;
        prev_d = ph_q;
      end
    end else begin
      cc_d   = '0;
      ph_d   = phase_in;
      prev_d = IDLE_P;   // puts no tail into period 0
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q   <= '0;
      ph_q   <= '0;
      prev_q <= IDLE_P;
    end else begin
      cc_q   <= cc_d;
      ph_q   <= ph_d;
      prev_q <= prev_d;
    end
  end

  assign carr_o.level = main_on | tail_on;
  assign carr_o.ends  = main_end | tail_end;

endmodule

// File: rtl/ifgate_pdm_if_gate.sv
module ifgate_pdm_if_gate #(
  parameter int ENV_BITS = 7,
  parameter int IFP_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [ENV_BITS-1:0] env_in,
  input  logic [IFP_BITS-1:0] if_period,
  output logic                gate_o,
  output logic                if_last_o,
  output logic [IFP_BITS-1:0] ic_o
);

  localparam int PW = IFP_BITS + ENV_BITS;

  logic [IFP_BITS-1:0] ic_q, ic_d;
  logic [ENV_BITS-1:0] env_q, env_d;
  logic [PW-1:0]       prod;
  logic                if_last;

  assign prod    = {{IFP_BITS{1'b0}}, env_q} * {{ENV_BITS{1'b0}}, if_period};
  assign if_last = (ic_q == (if_period - IFP_BITS'(1)));

  always_comb begin
    ic_d  = ic_q;
    env_d = env_q;
    if (run) begin
      if (if_last) begin
        ic_d  = '0;
        env_d = env_in;
      end else begin
        ic_d = ic_q + 1'b1;
      end
    end else begin
      ic_d  = '0;
      env_d = env_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q  <= '0;
      env_q <= '0;
    end else begin
      ic_q  <= ic_d;
      env_q <= env_d;
    end
  end

  assign gate_o    = ({{ENV_BITS{1'b0}}, ic_q} < (prod >> ENV_BITS));
  assign if_last_o = if_last;
  assign ic_o      = ic_q;

endmodule

// File: rtl/ifgate_pdm_whole_cnt.sv
module ifgate_pdm_whole_cnt #(
  parameter int IFP_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                hit,
  input  logic                if_last,
  output logic [IFP_BITS-1:0] cnt_o
);

  logic [IFP_BITS-1:0] acc_q, acc_d, cnt_q, cnt_d, acc_inc;

  assign acc_inc = acc_q + {{(IFP_BITS-1){1'b0}}, hit};

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (run) begin
      if (if_last) begin
        acc_d = '0;
        cnt_d = acc_inc;
      end else begin
        acc_d = acc_inc;
      end
    end else begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ifgate_pdm.sv
module ifgate_pdm
  import ifgate_pdm_pkg::*;
#(
  parameter int PH_BITS  = 8,
  parameter int ENV_BITS = 7,
  parameter int IFP_BITS = 16,
  parameter int FC_BITS  = 11,
  parameter int BAND_UP  = 100,
  parameter int BAND_DN  = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_en,
  input  logic [FC_BITS-1:0]  fc_code,
  input  logic [PH_BITS-1:0]  phase_in,
  input  logic [ENV_BITS-1:0] env_in,
  input  logic [IFP_BITS-1:0] if_period,
  output logic                pdm_out,
  output logic                band_high,
  output logic                cfg_err_ratio,
  output logic                cfg_err_short,
  output logic [IFP_BITS-1:0] whole_cnt
);

  localparam int CP      = 1 << PH_BITS;
  localparam int H       = CP / 2;
  localparam int ENV_MIN = ((1 << ENV_BITS) + 9) / 10;
  localparam int MIN_WIN = 2 * CP + H - 1;
  localparam int PW      = IFP_BITS + ENV_BITS;
  localparam logic [ENV_BITS-1:0] ENV_MIN_W = ENV_BITS'(ENV_MIN);
  localparam logic [PW-1:0]       MIN_WIN_W = PW'(MIN_WIN);
  localparam logic [IFP_BITS-1:0] H1_W      = IFP_BITS'(H - 1);

  band_e               band;
  carr_t               carr;
  logic                gate, if_last, run, hit;
  logic [IFP_BITS-1:0] ic;
  logic [PW-1:0]       min_prod;
  logic                out_q, out_d;

  // configuration screening
  assign cfg_err_ratio = (if_period[PH_BITS-2:0] == '0);
  assign min_prod      = {{IFP_BITS{1'b0}}, ENV_MIN_W} * {{ENV_BITS{1'b0}}, if_period};
  assign cfg_err_short = ((min_prod >> ENV_BITS) < MIN_WIN_W);

  assign band_high = (band == BAND_HIGH);
  assign run       = mode_en && band_high && !cfg_err_ratio && !cfg_err_short;

  ifgate_pdm_band_sel #(
    .FC_BITS (FC_BITS),
    .BAND_UP (BAND_UP),
    .BAND_DN (BAND_DN)
  ) u_band (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_code (fc_code),
    .band_o  (band)
  );

  ifgate_pdm_carrier #(
    .PH_BITS (PH_BITS)
  ) u_carr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .phase_in (phase_in),
    .carr_o   (carr)
  );

  ifgate_pdm_if_gate #(
    .ENV_BITS (ENV_BITS),
    .IFP_BITS (IFP_BITS)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .env_in    (env_in),
    .if_period (if_period),
    .gate_o    (gate),
    .if_last_o (if_last),
    .ic_o      (ic)
  );

  // a pulse is whole when it ends inside the window and began in the same IF period
  assign hit = carr.ends && gate && (ic >= H1_W);

  ifgate_pdm_whole_cnt #(
    .IFP_BITS (IFP_BITS)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hit     (hit),
    .if_last (if_last),
    .cnt_o   (whole_cnt)
  );

  always_comb begin
    out_d = run && carr.level && gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign pdm_out = out_q;

endmodule

// File: rtl/ifgate_pdm_chk.sv
module ifgate_pdm_chk #(
  parameter int PH_BITS = 8,
  parameter int FC_BITS = 11,
  parameter int BAND_UP = 100,
  parameter int BAND_DN = 80
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_en,
  input logic [FC_BITS-1:0] fc_code,
  input logic               band_high,
  input logic               pdm_out,
  input logic               cfg_err_ratio,
  input logic               cfg_err_short
);

  localparam int CP = 1 << PH_BITS;
  localparam int RW = PH_BITS + 2;
  localparam logic [FC_BITS-1:0] UP_W  = FC_BITS'(BAND_UP);
  localparam logic [FC_BITS-1:0] DN_W  = FC_BITS'(BAND_DN);
  localparam logic [RW-1:0]      CAP_W = RW'(CP);

  // length of the current run of high output ticks, saturating
  logic [RW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
    end else if (!pdm_out) begin
      hi_run <= '0;
    end else if (hi_run <= CAP_W) begin
      hi_run <= hi_run + 1'b1;
    end
  end

  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= CAP_W);

  p_ratio_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_ratio |=> !pdm_out);

  p_short_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_short |=> !pdm_out);

  p_band_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_code > UP_W) |=> band_high);

  p_band_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_code < DN_W) |=> !band_high);

  p_band_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fc_code >= DN_W) && (fc_code <= UP_W)) |=> $stable(band_high));

  p_off_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en || !band_high) |=> !pdm_out);

endmodule

bind ifgate_pdm ifgate_pdm_chk #(
  .PH_BITS (PH_BITS),
  .FC_BITS (FC_BITS),
  .BAND_UP (BAND_UP),
  .BAND_DN (BAND_DN)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_en       (mode_en),
  .fc_code       (fc_code),
  .band_high     (band_high),
  .pdm_out       (pdm_out),
  .cfg_err_ratio (cfg_err_ratio),
  .cfg_err_short (cfg_err_short)
);

// File: tb/sim_ifgate_pdm.sv
module sim_ifgate_pdm;

  localparam int CLK_PERIOD = 10;
  localparam int PB   = 4;
  localparam int EB   = 4;
  localparam int IB   = 12;
  localparam int FB   = 11;
  localparam int CP   = 16;
  localparam int H    = 8;
  localparam int EMIN = 2;

  logic          clk;
  logic          rst_n;
  logic          mode_en;
  logic [FB-1:0] fc_code;
  logic [PB-1:0] phase_in;
  logic [EB-1:0] env_in;
  logic [IB-1:0] if_period;
  logic          pdm_out, band_high, cfg_err_ratio, cfg_err_short;
  logic [IB-1:0] whole_cnt;

  int checks = 0;
  int errors = 0;
  int cur_ifp = 313;
  int cur_pat = 0;

  ifgate_pdm #(
    .PH_BITS (PB), .ENV_BITS (EB), .IFP_BITS (IB),
    .FC_BITS (FB), .BAND_UP (100), .BAND_DN (80)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .mode_en (mode_en), .fc_code (fc_code),
    .phase_in (phase_in), .env_in (env_in), .if_period (if_period),
    .pdm_out (pdm_out), .band_high (band_high),
    .cfg_err_ratio (cfg_err_ratio), .cfg_err_short (cfg_err_short),
    .whole_cnt (whole_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ph_of(int pat, int n);
    case (pat)
      0:       return 5;
      1:       return (n * 7) % CP;
      2:       return (n % 2 == 1) ? CP - 1 : 0;
      default: return (n * 3 + 1) % CP;
    endcase
  endfunction

  function automatic int env_of(int pat, int m);
    case (pat)
      0:       return m % 16;
      1:       return 15 - (m % 16);
      2:       return EMIN + (m % 3);
      default: return (m * 5) % 16;
    endcase
  endfunction

  function automatic int hi_of(int m);
    return (env_of(cur_pat, m) * cur_ifp) / 16;
  endfunction

  function automatic bit exp_out(int k);
    int n = k / CP;
    int pos = k % CP;
    bit carr;
    bit gate;
    carr = (pos >= ph_of(cur_pat, n) && pos < ph_of(cur_pat, n) + H) ||
           (n > 0 && pos + CP < ph_of(cur_pat, n - 1) + H);
    gate = (k % cur_ifp) < hi_of(k / cur_ifp);
    return carr && gate;
  endfunction

  function automatic int exp_cnt(int m);
    int lo = (m * cur_ifp) / CP - 2;
    int up = ((m + 1) * cur_ifp) / CP + 1;
    int c = 0;
    if (lo < 0) lo = 0;
    for (int n = lo; n <= up; n++) begin
      int s = n * CP + ph_of(cur_pat, n);
      if (s >= m * cur_ifp && s + H <= m * cur_ifp + hi_of(m)) c++;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic band_step(input int code, input bit exp);
    @(negedge clk);
    fc_code = FB'(code);
    @(negedge clk);
    chk(band_high == exp, "R10 band", int'(band_high), int'(exp));
  endtask

  task automatic run_seg(input int ifp, input int pat, input int nper);
    @(negedge clk);
    mode_en   = 1'b0;
    if_period = IB'(ifp);
    cur_ifp   = ifp;
    cur_pat   = pat;
    phase_in  = PB'(ph_of(pat, 0));
    env_in    = EB'(env_of(pat, 0));
    repeat (2) @(negedge clk);
    chk(!cfg_err_ratio && !cfg_err_short, "R7 R8 valid config", int'(cfg_err_ratio), 0);
    chk(pdm_out == 1'b0, "R11 idle output", int'(pdm_out), 0);
    mode_en  = 1'b1;
    phase_in = PB'(ph_of(pat, 1));
    env_in   = EB'(env_of(pat, 1));
    for (int k = 0; k < nper * ifp; k++) begin
      @(negedge clk);
      chk(pdm_out == exp_out(k), "R2 R3 R4 R5 output tick", int'(pdm_out), int'(exp_out(k)));
      if (k % ifp == ifp - 1) begin
        chk(int'(whole_cnt) == exp_cnt(k / ifp), "R6 whole count", int'(whole_cnt), exp_cnt(k / ifp));
        if (env_of(pat, k / ifp) >= EMIN)
          chk(whole_cnt >= 1, "R9 minimum envelope", int'(whole_cnt), 1);
      end
      if (k % CP == CP - 1) phase_in = PB'(ph_of(pat, (k + 1) / CP + 1));
      if (k % ifp == ifp - 1) env_in = EB'(env_of(pat, (k + 1) / ifp + 1));
      if (pat == 3) begin
        // R5: disturb inputs away from the sampling ticks
        if (k % CP == 3) phase_in = ~phase_in;
        if (k % CP == CP - 2) phase_in = PB'(ph_of(pat, (k + 2) / CP));
        if (k % ifp == 10) env_in = ~env_in;
        if (k % ifp == ifp - 2) env_in = EB'(env_of(pat, (k + 2) / ifp));
      end
    end
    @(negedge clk);
    mode_en = 1'b0;
  endtask

  task automatic err_case(input int ifp, input bit er, input bit es);
    @(negedge clk);
    if_period = IB'(ifp);
    mode_en   = 1'b1;
    @(negedge clk);
    chk(cfg_err_ratio == er, "R7 ratio flag", int'(cfg_err_ratio), int'(er));
    chk(cfg_err_short == es, "R8 short flag", int'(cfg_err_short), int'(es));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(pdm_out == 1'b0, "R7 R8 output held low", int'(pdm_out), 0);
    end
    mode_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    mode_en   = 1'b0;
    fc_code   = FB'(150);
    phase_in  = '0;
    env_in    = '0;
    if_period = IB'(313);
    repeat (3) @(negedge clk);
    chk(pdm_out == 1'b0, "R1 reset output", int'(pdm_out), 0);
    chk(band_high == 1'b0, "R1 reset band", int'(band_high), 0);
    chk(whole_cnt == '0, "R1 reset count", int'(whole_cnt), 0);
    rst_n = 1'b1;

    // R10: hysteresis walk
    band_step(90, 1'b1);
    band_step(79, 1'b0);
    band_step(100, 1'b0);
    band_step(101, 1'b1);
    band_step(90, 1'b1);
    band_step(80, 1'b1);
    band_step(79, 1'b0);

    // R11: low band keeps the output quiet even when enabled
    @(negedge clk);
    fc_code   = FB'(50);
    if_period = IB'(313);
    env_in    = EB'(15);
    mode_en   = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(pdm_out == 1'b0, "R11 low band", int'(pdm_out), 0);
    end
    mode_en = 1'b0;
    band_step(150, 1'b1);

    // R7 / R8: rejected configurations
    err_case(312, 1'b1, 1'b0);
    err_case(0, 1'b1, 1'b1);
    err_case(305, 1'b0, 1'b1);

    // sweeps over phase and envelope codes
    run_seg(313, 0, 17);
    run_seg(315, 1, 17);
    run_seg(317, 2, 20);
    run_seg(401, 3, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule